// File: doc/BRIEF.md
# PLL bring-up sequencer

This block brings one phase-locked loop from an arbitrary state into service with a requested divisor set. It takes three divisors: the reference pre-divider NR, the feedback multiplier NF and the output post-divider NO. It then steps the PLL's control fields in a fixed order. First the PLL is parked on its reference in slow mode and held in reset. Next the divider fields and the loop-bandwidth field are written. After a settle interval the reset is removed. The sequencer then waits for the lock indication and finally switches the output to normal mode. A lock that never arrives ends the attempt with an error flag, and the PLL is left running from the reference.

The same block also reports the output frequency the PLL currently delivers. It works this out from the mode field and the stored divider fields, so software-free logic elsewhere in the chip can read a rate without tracking the sequence itself. The analog loop is outside the block: the lock input comes from the PLL macro, or from a behavioural stand-in during verification.

Top module: `pll_bringup_seq`

## Requirements
- R1: A start strobe accepted while idle sets, one clock later and in the same cycle, the mode field to slow (2'b00), the PLL reset output high and busy high; the error flag is cleared at that point.
- R2: One clock after R1, the stored divider fields hold NR-1, NF-1 and NO-1 of the divisors presented with the accepted start strobe.
- R3: In the same cycle as R2, the bandwidth field holds floor(NF/2)-1.
- R4: After the divider fields are written, the PLL reset stays high for exactly SETTLE_CYC = CLK_HZ*SETTLE_US/1,000,000 clocks and is then released, while the mode is still slow.
- R5: After the reset is released, the lock input is sampled on every clock. One clock after the first cycle in which it is seen high, the mode becomes normal (2'b01) and busy falls.
- R6: The done output is high for exactly one clock, and that clock is the first one in normal mode.
- R7: If lock stays low for LOCK_TIMEOUT clocks after the reset release, the error flag rises, busy falls, the mode stays slow and done stays low.
- R8: A start strobe or a deep-slow request that arrives while busy is ignored: the fields, the settle length and the final mode are those of the accepted sequence.
- R9: The rate output reads REF_HZ (24,000,000 by default) in slow mode and 32,768 in deep-slow mode.
- R10: In normal mode the rate output reads floor(24*NF/(NR*NO)) times 1,000,000, with each divisor decoded as its stored field plus one. The result is truncated to RATE_W bits.
- R11: A deep-slow request while idle sets the mode field to deep-slow (2'b10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a bring-up with the presented divisors |
| deep_req_i | input | 1 | Park the PLL output in deep-slow mode |
| nr_i | input | NR_W | Reference pre-divider, 1 or more |
| nf_i | input | NF_W | Feedback multiplier, 2 or more |
| no_i | input | NO_W | Output post-divider, 1 or more |
| lock_i | input | 1 | Lock indication from the PLL |
| mode_o | output | 2 | Mode field: 00 slow, 01 normal, 10 deep-slow |
| pll_rst_o | output | 1 | PLL reset field |
| nr_fld_o | output | NR_W | Stored pre-divider field (value minus one) |
| nf_fld_o | output | NF_W | Stored multiplier field (value minus one) |
| no_fld_o | output | NO_W | Stored post-divider field (value minus one) |
| bw_fld_o | output | BW_W | Bandwidth adjust field |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock pulse on entry to normal mode |
| err_o | output | 1 | Lock timeout seen on the last attempt |
| rate_o | output | RATE_W | Current output frequency in Hz |

## Verification
Several rules are checked by assertions on every cycle. The entry into a sequence must show slow mode and reset together. The reset release must happen only in slow mode. Normal mode may be entered only after lock was seen with the reset released. Done must be a single-cycle pulse tied to normal mode. A timeout must leave the PLL slow. The shared wait counter must never decrement through zero. Other behaviour can only be shown by the bench scenarios: the exact field encodings, the bandwidth value, the exact settle and timeout lengths in clocks, the rejection of a strobe that arrives mid-sequence, and the rate arithmetic over random divisor sets.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [1:0] {
      MODE_SLOW   = 2'b00,
      MODE_NORMAL = 2'b01,
      MODE_DEEP   = 2'b10
   } pll_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_PROG   = 2'd1,
      ST_SETTLE = 2'd2,
      ST_LOCK   = 2'd3
   } seq_state_e;

   localparam int unsigned DEEP_SLOW_HZ = 32768;

endpackage

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             dec_i,
   output logic             zero_o
);

   if (CNT_W < 1) begin : g_bad_width
      $error("pll_wait_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (dec_i) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   AST_TMR_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dec_i && !load_i) |-> (cnt_q != '0)); // R4

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
   import pll_seq_pkg::*;
#(
   parameter int unsigned NR_W      = 6,
   parameter int unsigned NF_W      = 13,
   parameter int unsigned NO_W      = 4,
   parameter int unsigned RATE_W    = 32,
   parameter int unsigned REF_HZ    = 24_000_000,
   parameter bit          MHZ_GRAIN = 1'b1
) (
   input  pll_mode_e         mode_i,
   input  logic [NR_W-1:0]   nr_fld_i,
   input  logic [NF_W-1:0]   nf_fld_i,
   input  logic [NO_W-1:0]   no_fld_i,
   output logic [RATE_W-1:0] rate_o
);

   localparam longint unsigned REF_L   = longint'(REF_HZ);
   localparam longint unsigned REF_MHZ = REF_L / 64'd1000000;

   if (RATE_W < 17 || RATE_W > 64) begin : g_bad_rate
      $error("pll_rate_calc: RATE_W must lie in 17..64");
   end
   if (NR_W + NO_W + NF_W > 40) begin : g_bad_fields
      $error("pll_rate_calc: divider fields too wide for 64-bit arithmetic");
   end

   logic [63:0] nr_dec, nf_dec, no_dec, den, rate_norm;

   assign nr_dec = 64'(nr_fld_i) + 64'd1;
   assign nf_dec = 64'(nf_fld_i) + 64'd1;
   assign no_dec = 64'(no_fld_i) + 64'd1;
   assign den    = nr_dec * no_dec;

   if (MHZ_GRAIN) begin : g_mhz_grain
      assign rate_norm = ((REF_MHZ * nf_dec) / den) * 64'd1000000;
   end else begin : g_hz_grain
      assign rate_norm = (REF_L * nf_dec) / den;
   end

   always_comb begin
      unique case (mode_i)
         MODE_NORMAL: rate_o = RATE_W'(rate_norm);
         MODE_DEEP:   rate_o = RATE_W'(DEEP_SLOW_HZ);
         default:     rate_o = RATE_W'(REF_L);
      endcase
   end

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
   import pll_seq_pkg::*;
#(
   parameter int unsigned NR_W         = 6,
   parameter int unsigned NF_W         = 13,
   parameter int unsigned NO_W         = 4,
   parameter int unsigned BW_W         = 12,
   parameter int unsigned RATE_W       = 32,
   parameter int unsigned REF_HZ       = 24_000_000,
   parameter int unsigned CLK_HZ       = 24_000_000,
   parameter int unsigned SETTLE_US    = 10,
   parameter int unsigned LOCK_TIMEOUT = 4096,
   parameter bit          MHZ_GRAIN    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              deep_req_i,
   input  logic [NR_W-1:0]   nr_i,
   input  logic [NF_W-1:0]   nf_i,
   input  logic [NO_W-1:0]   no_i,
   input  logic              lock_i,
   output logic [1:0]        mode_o,
   output logic              pll_rst_o,
   output logic [NR_W-1:0]   nr_fld_o,
   output logic [NF_W-1:0]   nf_fld_o,
   output logic [NO_W-1:0]   no_fld_o,
   output logic [BW_W-1:0]   bw_fld_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [RATE_W-1:0] rate_o
);

   localparam longint unsigned SETTLE_L   =
      longint'(CLK_HZ) * longint'(SETTLE_US) / 64'd1000000;
   localparam int unsigned     SETTLE_CYC = int'(SETTLE_L);
   localparam int unsigned     TMR_MAX    =
      (SETTLE_CYC > LOCK_TIMEOUT) ? SETTLE_CYC : LOCK_TIMEOUT;
   localparam int unsigned     TMR_W      = $clog2(TMR_MAX + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("pll_bringup_seq: settle interval rounds to zero clocks");
   end
   if (LOCK_TIMEOUT < 1) begin : g_bad_timeout
      $error("pll_bringup_seq: LOCK_TIMEOUT must be at least 1");
   end
   if (BW_W + 1 < NF_W) begin : g_bad_bw
      $error("pll_bringup_seq: BW_W cannot hold NF/2");
   end
   if (NF_W < 2 || NR_W < 1 || NO_W < 1) begin : g_bad_div
      $error("pll_bringup_seq: divider widths too small");
   end

   seq_state_e      st_q;
   pll_mode_e       mode_q;
   logic [NR_W-1:0] hold_nr_q;
   logic [NF_W-1:0] hold_nf_q;
   logic [NO_W-1:0] hold_no_q;
   logic            tmr_load, tmr_dec, tmr_zero;
   logic [TMR_W-1:0] tmr_val;

   // Shared wait counter: settle length first, then the lock window.
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = TMR_W'(SETTLE_CYC - 1);
      if (st_q == ST_PROG) begin
         tmr_load = 1'b1;
      end else if (st_q == ST_SETTLE && tmr_zero) begin
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(LOCK_TIMEOUT - 1);
      end
      tmr_dec = (st_q == ST_SETTLE || st_q == ST_LOCK) && !tmr_zero && !tmr_load;
   end

   pll_wait_timer #(.CNT_W(TMR_W)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .dec_i      (tmr_dec),
      .zero_o     (tmr_zero)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         mode_q    <= MODE_SLOW;
         pll_rst_o <= 1'b0;
         nr_fld_o  <= '0;
         nf_fld_o  <= '0;
         no_fld_o  <= '0;
         bw_fld_o  <= '0;
         hold_nr_q <= '0;
         hold_nf_q <= '0;
         hold_no_q <= '0;
         busy_o    <= 1'b0;
         done_o    <= 1'b0;
         err_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  hold_nr_q <= nr_i;
                  hold_nf_q <= nf_i;
                  hold_no_q <= no_i;
                  mode_q    <= MODE_SLOW;
                  pll_rst_o <= 1'b1;
                  busy_o    <= 1'b1;
                  err_o     <= 1'b0;
                  st_q      <= ST_PROG;
               end else if (deep_req_i) begin
                  mode_q <= MODE_DEEP;
               end
            end
            ST_PROG: begin
               nr_fld_o <= hold_nr_q - 1'b1;
               nf_fld_o <= hold_nf_q - 1'b1;
               no_fld_o <= hold_no_q - 1'b1;
               bw_fld_o <= BW_W'((hold_nf_q >> 1) - 1'b1);
               st_q     <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (tmr_zero) begin
                  pll_rst_o <= 1'b0;
                  st_q      <= ST_LOCK;
               end
            end
            ST_LOCK: begin
               if (lock_i) begin
                  mode_q <= MODE_NORMAL;
                  done_o <= 1'b1;
                  busy_o <= 1'b0;
                  st_q   <= ST_IDLE;
               end else if (tmr_zero) begin
                  err_o  <= 1'b1;
                  busy_o <= 1'b0;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign mode_o = mode_q;

   pll_rate_calc #(
      .NR_W      (NR_W),
      .NF_W      (NF_W),
      .NO_W      (NO_W),
      .RATE_W    (RATE_W),
      .REF_HZ    (REF_HZ),
      .MHZ_GRAIN (MHZ_GRAIN)
   ) u_rate (
      .mode_i   (mode_q),
      .nr_fld_i (nr_fld_o),
      .nf_fld_i (nf_fld_o),
      .no_fld_i (no_fld_o),
      .rate_o   (rate_o)
   );

   AST_ENTRY_SLOW_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (pll_rst_o && mode_o == 2'b00)); // R1
   AST_RELEASE_IN_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pll_rst_o) |-> (mode_o == 2'b00 && busy_o)); // R4
   AST_NORMAL_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b01 && $past(mode_o) != 2'b01) |-> ($past(lock_i) && !pll_rst_o)); // R5
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R6
   AST_DONE_IN_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (mode_o == 2'b01 && !busy_o)); // R6
   AST_TIMEOUT_STAYS_SLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> (mode_o == 2'b00 && !busy_o && !done_o)); // R7

endmodule

// File: tb/tb_pll_bringup_seq.sv
module tb_pll_bringup_seq;

   localparam int CLK_PERIOD = 10;
   localparam int TB_CLK_HZ  = 2_400_000;
   localparam int SETTLE     = 24;
   localparam int TMO        = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, deep_req = 1'b0, lock = 1'b0;
   logic [5:0]  nr = '0;
   logic [12:0] nf = '0;
   logic [3:0]  no = '0;
   logic [1:0]  mode;
   logic        pll_rst, busy, done, err;
   logic [5:0]  nr_fld;
   logic [12:0] nf_fld;
   logic [3:0]  no_fld;
   logic [11:0] bw_fld;
   logic [31:0] rate;

   int total = 0, fails = 0;
   int stub_dly = 0;
   bit stub_en = 1'b0;
   int stub_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pll_bringup_seq #(
      .CLK_HZ       (TB_CLK_HZ),
      .LOCK_TIMEOUT (TMO)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .deep_req_i(deep_req),
      .nr_i(nr), .nf_i(nf), .no_i(no), .lock_i(lock),
      .mode_o(mode), .pll_rst_o(pll_rst), .nr_fld_o(nr_fld), .nf_fld_o(nf_fld),
      .no_fld_o(no_fld), .bw_fld_o(bw_fld), .busy_o(busy), .done_o(done),
      .err_o(err), .rate_o(rate)
   );

   // Behavioural PLL: lock rises stub_dly cycles after reset is released.
   always @(negedge clk) begin
      if (pll_rst || !stub_en) begin
         stub_cnt = 0;
         lock     = 1'b0;
      end else if (stub_cnt == stub_dly) begin
         lock = 1'b1;
      end else begin
         stub_cnt++;
      end
   end

   function automatic logic [31:0] exp_norm(int r, int f, int o);
      longint v;
      v = (longint'(24) * f / (r * o)) * 64'd1000000;
      return v[31:0];
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   task automatic run_seq(int r, int f, int o, int dly, bit lock_ok, bit poke);
      int cnt;
      @(negedge clk);
      nr = 6'(r); nf = 13'(f); no = 4'(o);
      stub_dly = dly; stub_en = lock_ok;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R1 busy", busy, 1); chk("R1 reset", pll_rst, 1);
      chk("R1 mode", mode, 0); chk("R1/R7 err cleared", err, 0);
      if (poke) begin
         nr = 6'd3; nf = 13'd99; no = 4'd5; start = 1'b1; deep_req = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; deep_req = 1'b0;
      chk("R2 nr field", nr_fld, r - 1);
      chk("R2 nf field", nf_fld, f - 1);
      chk("R2 no field", no_fld, o - 1);
      chk("R3 bw field", bw_fld, (f / 2) - 1);
      if (poke) begin
         @(negedge clk);
         start = 1'b1; deep_req = 1'b1; nf = 13'd77;
         @(negedge clk);
         start = 1'b0; deep_req = 1'b0;
         cnt = 2;
      end else begin
         cnt = 0;
      end
      while (pll_rst === 1'b1 && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      chk("R4 settle length", cnt, SETTLE);
      chk("R4 mode at release", mode, 0);
      cnt = 0;
      while (done !== 1'b1 && err !== 1'b1 && cnt < 1000) begin
         @(negedge clk);
         cnt++;
      end
      if (lock_ok) begin
         chk("R5 lock to normal", cnt, dly + 1);
         chk("R5 mode normal", mode, 1);
         chk("R5 busy low", busy, 0);
         chk("R10 rate", rate, exp_norm(r, f, o));
         if (poke) begin
            chk("R8 nf kept", nf_fld, f - 1);
            chk("R8 nr kept", nr_fld, r - 1);
         end
         @(negedge clk);
         chk("R6 done one cycle", done, 0);
      end else begin
         chk("R7 timeout length", cnt, TMO);
         chk("R7 err", err, 1);
         chk("R7 mode slow", mode, 0);
         chk("R7 no done", done, 0);
         chk("R9 slow rate", rate, 24_000_000);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      $display("FAIL watchdog expired");
      total++; fails++;
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset mode", mode, 0); chk("R9 reset pll_rst", pll_rst, 0);
      chk("R9 reset busy", busy, 0); chk("R6 reset done", done, 0);
      chk("R7 reset err", err, 0);   chk("R9 reset rate", rate, 24_000_000);

      deep_req = 1'b1;
      @(negedge clk);
      deep_req = 1'b0;
      chk("R11 deep mode", mode, 2); chk("R9 deep rate", rate, 32768);

      run_seq(1, 68, 2, 3, 1'b1, 1'b0);
      run_seq(12, 400, 2, 0, 1'b1, 1'b0);
      run_seq(2, 111, 1, 5, 1'b1, 1'b1);
      chk("R8 mode not deep", mode, 1);
      run_seq(4, 200, 3, 0, 1'b0, 1'b0);
      run_seq(1, 50, 1, 2, 1'b1, 1'b0);

      deep_req = 1'b1;
      @(negedge clk);
      deep_req = 1'b0;
      chk("R11 deep from normal", mode, 2); chk("R9 deep rate", rate, 32768);

      for (int i = 0; i < 30; i++) begin
         int r, f, o, d;
         r = 1 + int'($urandom % 16);
         o = 1 + int'($urandom % 8);
         f = 2 + int'($urandom % 4000);
         d = int'($urandom % 16);
         run_seq(r, f, o, d, 1'b1, (i % 7) == 3);
      end
      run_seq(64, 8191, 16, 1, 1'b1, 1'b0);
      run_seq(1, 2, 1, 0, 1'b1, 1'b0);

      summary();
      $finish;
   end

endmodule